// File: doc/BRIEF.md
# Three-Port Register File with Zero Register

This block holds the general-purpose registers of a single-cycle processor core. It has two read ports, A and B, that return data combinationally from their own addresses, and one write port that stores a word on the rising clock edge when its enable is high. The two operand fetches and the result write-back of one instruction can therefore all take place in the same cycle.

The highest-numbered register is the constant-zero register. Both read ports always return zero for it, whatever has been written there. A read of a register that is being written in the same cycle returns the contents from before the write. The new value appears only after the clock edge, and no forwarding path exists inside the block.

Storage has no reset. Software must write a register before it reads it, except for the zero register.

Top module: `regfile_3p`

## Requirements
- R1: Read ports A and B take separate 5-bit addresses. Each port returns the word stored at its own address, with no dependence on the other port's address.
- R2: When `wr_en` is 1 at a rising edge of `clk`, the word `wr_data` is stored in register `wr_addr`, and reads return it from that edge onward.
- R3: When `wr_en` is 0 at a rising edge, no register changes, whatever `wr_addr` and `wr_data` are.
- R4: Address 31 (5'b11111) reads as 32'h0 on both read ports at all times.
- R5: A write to address 31 is accepted but has no effect. Register 31 still reads 0, and every other register keeps its contents.
- R6: When `wr_addr` equals a read address with `wr_en` high, that read port returns the old contents until the rising edge and the new contents after it.
- R7: Both read ports may select the same address at once, and both then return the same word.
- R8: A read responds to a change of its address with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rd_addr_a | input | 5 | Read port A register number |
| rd_data_a | output | 32 | Read port A data, combinational |
| rd_addr_b | input | 5 | Read port B register number |
| rd_data_b | output | 32 | Read port B data, combinational |
| wr_addr | input | 5 | Write register number |
| wr_data | input | 32 | Word to store |
| wr_en | input | 1 | Write enable, sampled at the rising edge |

## Verification
Every register first gets a distinct pattern and is read back on both ports. Reading with differing and then equal addresses on the two ports shows whether the ports are truly independent or whether one shadows the other. Writes with the enable low and writes aimed at register 31 are each followed by a full read-back of all registers, which would reveal a stray store or a leak around the zero mask. A read of the register being written is sampled both before and after the edge, which tells a pre-write read apart from a forwarding path. A random mix of writes, disabled writes and reads on both ports is then compared against a model array, and address changes are checked with no clock edge in between.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_WIDTH = 32;
  localparam int unsigned RF_DEPTH = 32;
  localparam int unsigned RF_AW    = $clog2(RF_DEPTH);
  localparam int unsigned RF_NRD   = 2;

  typedef logic [RF_WIDTH-1:0] rf_word_t;
  typedef logic [RF_AW-1:0]    rf_addr_t;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned NRD   = 2,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [AW-1:0]    ra [NRD],
  output logic [WIDTH-1:0] rd [NRD]
);
  // Plain array with one synchronous write: maps to distributed RAM.
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd[p] = mem[ra[p]];
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned ZERO_REG = DEPTH - 1,
  localparam int unsigned AW      = $clog2(DEPTH)
) (
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] data
);
  localparam logic [AW-1:0] ZADDR = AW'(ZERO_REG);

  always_comb begin
    data = raw;
    if (addr == ZADDR) data = '0;
  end
endmodule

// File: rtl/regfile_3p.sv
module regfile_3p
  import rf_pkg::*;
#(
  parameter int unsigned WIDTH    = RF_WIDTH,
  parameter int unsigned DEPTH    = RF_DEPTH,
  parameter int unsigned ZERO_REG = DEPTH - 1,
  localparam int unsigned AW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [AW-1:0]    rd_addr_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_b,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en
);
  localparam int unsigned NRD = RF_NRD;
  localparam logic [AW-1:0] ZADDR = AW'(ZERO_REG);

  logic [AW-1:0]    ra   [NRD];
  logic [WIDTH-1:0] raw  [NRD];
  logic [WIDTH-1:0] rdat [NRD];

  assign ra[0] = rd_addr_a;
  assign ra[1] = rd_addr_b;

  rf_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NRD(NRD)) u_bank (
    .clk (clk),
    .we  (wr_en),
    .wa  (wr_addr),
    .wd  (wr_data),
    .ra  (ra),
    .rd  (raw)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    rf_read_port #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ZERO_REG(ZERO_REG)) u_port (
      .addr (ra[p]),
      .raw  (raw[p]),
      .data (rdat[p])
    );
  end

  assign rd_data_a = rdat[0];
  assign rd_data_b = rdat[1];

  // Checker state: last edge's write and the read values just before it.
  logic             armed_q = 1'b0;
  logic             we_q    = 1'b0;
  logic [AW-1:0]    wa_q;
  logic [WIDTH-1:0] wd_q;
  logic [AW-1:0]    sa_q;
  logic [WIDTH-1:0] sd_q;

  always_ff @(posedge clk) begin
    armed_q <= 1'b1;
    we_q    <= wr_en;
    wa_q    <= wr_addr;
    wd_q    <= wr_data;
    sa_q    <= rd_addr_a;
    sd_q    <= rd_data_a;
  end

  always_ff @(negedge clk) begin
    // R4: zero register on both ports
    p_zero_a_r4: assert (rd_addr_a != ZADDR || rd_data_a == '0);
    p_zero_b_r4: assert (rd_addr_b != ZADDR || rd_data_b == '0);
    // R2: an enabled write is visible after its edge
    if (we_q && wa_q != ZADDR && rd_addr_a == wa_q)
      p_commit_r2: assert (rd_data_a == wd_q);
    // R3 / R6: an untouched register holds the value read before the edge
    if (armed_q && rd_addr_a == sa_q && !(we_q && wa_q == sa_q))
      p_hold_r3: assert (rd_data_a == sd_q);
    // R7: same address on both ports gives the same word
    if (rd_addr_a == rd_addr_b)
      p_same_r7: assert (rd_data_a == rd_data_b);
  end
endmodule

// File: tb/sim_regfile_3p.sv
module sim_regfile_3p;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam logic [4:0] Z = 5'd31;

  logic        clk = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        wr_en = 1'b0;

  logic [31:0] model [N];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_3p u0 (
    .clk(clk), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en)
  );

  function automatic logic [31:0] expv(input logic [4:0] a);
    return (a == Z) ? 32'h0 : model[a];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic en);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (en && a != Z) model[a] = d;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < N; i++) begin
      rd_addr_a = 5'(i); rd_addr_b = 5'(N - 1 - i); #1;
      chk(req, rd_data_a, expv(5'(i)));
      chk(req, rd_data_b, expv(5'(N - 1 - i)));
    end
  endtask

  task automatic t_zero_initial();
    rd_addr_a = Z; rd_addr_b = Z; #1;
    chk("R4 initial A", rd_data_a, 32'h0);
    chk("R4 initial B", rd_data_b, 32'h0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < N; i++) wr(5'(i), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101), 1'b1);
    read_all("R1 R2 fill readback");
  endtask

  task automatic t_disabled();
    for (int i = 0; i < 8; i++) wr(5'(i * 3), 32'hDEAD_0000 + 32'(i), 1'b0);
    read_all("R3 disabled write");
  endtask

  task automatic t_zero_write();
    wr(Z, 32'hFFFF_FFFF, 1'b1);
    wr(Z, 32'h1234_5678, 1'b1);
    rd_addr_a = Z; rd_addr_b = Z; #1;
    chk("R5 zero reg A", rd_data_a, 32'h0);
    chk("R5 zero reg B", rd_data_b, 32'h0);
    read_all("R5 others intact");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    rd_addr_a = 5'd5; rd_addr_b = 5'd5;
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'h0BAD_F00D;
    #1;
    chk("R6 old value A", rd_data_a, model[5]);
    chk("R6 old value B", rd_data_b, model[5]);
    @(posedge clk); #1;
    wr_en = 1'b0; model[5] = 32'h0BAD_F00D;
    chk("R6 new value A", rd_data_a, model[5]);
    chk("R6 new value B", rd_data_b, model[5]);
  endtask

  task automatic t_same_addr_and_comb();
    @(negedge clk);
    rd_addr_a = 5'd9; rd_addr_b = 5'd9; #1;
    chk("R7 same addr A", rd_data_a, model[9]);
    chk("R7 same addr B", rd_data_b, model[9]);
    rd_addr_a = 5'd12; #1;
    chk("R8 comb change A", rd_data_a, model[12]);
    chk("R1 B unaffected", rd_data_b, model[9]);
    rd_addr_b = 5'd20; #1;
    chk("R8 comb change B", rd_data_b, model[20]);
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      logic [4:0] a = 5'($urandom_range(0, 31));
      logic [31:0] d = $urandom;
      logic en = 1'($urandom_range(0, 1));
      wr(a, d, en);
      rd_addr_a = 5'($urandom_range(0, 31));
      rd_addr_b = 5'($urandom_range(0, 31)); #1;
      chk("R1 R2 R3 random A", rd_data_a, expv(rd_addr_a));
      chk("R1 R2 R3 random B", rd_data_b, expv(rd_addr_b));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_zero_initial();
    t_fill();
    t_disabled();
    t_zero_write();
    t_same_cycle();
    t_same_addr_and_comb();
    t_random();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule